// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block provides message passing between two processors that sit on opposite sides of a shared dual-port memory. Each side owns a small set of word-wide mailboxes. It may read and write them, and the other side may only read them. Any write that carries the most significant byte of a mailbox raises an interrupt source toward the other side. That source stays pending until the other side reads the same mailbox's upper byte. The read leaves the mailbox contents as they were.

Every side has its own register window. The window holds the side's own mailboxes, a read-only view of the peer's mailboxes, a per-source mask, a cause register and a status register. The cause register records only sources that were unmasked at the moment they fired, and it drives the active-low interrupt pin. The status register reports every pending source, masked or not. Both sides run on one clock. Read data is registered, and interrupts take effect on the edge that captures the write.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: A side performs a mailbox access on a clock edge only when its mailbox select (`x_box_n`) is low and its memory enable (`x_mem_en`) is low. In any other cycle the side's registers, its interrupt state and its read data do not change.
- R2: Register window offsets, with N = NUM_BOX (4 by default), are as follows. Offsets 0..N-1 are the side's own mailboxes. Offsets N..2N-1 are the peer's mailboxes, read-only. Offset 2N is the mask. Offset 2N+1 is cause and offset 2N+2 is status, both read-only. Any other offset reads as zero.
- R3: A write to an own mailbox updates only the byte lanes whose enable bit is set, where bit k covers data bits 8k+7..8k. Writes to the peer, cause, status or unmapped offsets change nothing.
- R4: Read data appears on `x_rdata` on the edge that follows the read request and holds until the next read. The value returned is what the register held before any write in that same cycle.
- R5: A write by one side to its own mailbox i with the upper byte enable (bit BYTES-1) set makes source i pending toward the other side. A write without that enable raises nothing.
- R6: A read by a side of peer offset N+i with the upper byte enable set clears that side's pending source i. A read without that enable leaves the source pending. Neither read changes the mailbox contents.
- R7: Mask bit i (mask register bits N-1..0) blocks source i from reaching the cause register and the interrupt pin. The mask is written from `x_wdata[N-1:0]` and reads back in the low N bits with the rest zero.
- R8: Cause bit i is set only when source i fires while mask bit i is clear. Cause bit i clears when the source is cleared. Changing the mask later does not set any cause bit.
- R9: Status bit i equals the pending state of source i, whatever the mask holds.
- R10: `x_irq_n` is low exactly when the side's cause register is non-zero. It falls on the edge that captures the raising write.
- R11: When a raising write and a clearing read hit the same source on the same edge, the source stays pending.
- R12: After reset, all mailboxes, masks, cause and status registers and read data are zero, and both interrupt pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_box_n | input | 1 | Side A mailbox select, active low |
| a_mem_en | input | 1 | Side A memory enable; mailbox access needs it low |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_be | input | DATA_W/8 | Side A byte lane enables |
| a_addr | input | ADDR_W | Side A register offset |
| a_wdata | input | DATA_W | Side A write data |
| a_rdata | output | DATA_W | Side A registered read data |
| a_irq_n | output | 1 | Interrupt toward side A, active low |
| b_box_n | input | 1 | Side B mailbox select, active low |
| b_mem_en | input | 1 | Side B memory enable; mailbox access needs it low |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_be | input | DATA_W/8 | Side B byte lane enables |
| b_addr | input | ADDR_W | Side B register offset |
| b_wdata | input | DATA_W | Side B write data |
| b_rdata | output | DATA_W | Side B registered read data |
| b_irq_n | output | 1 | Interrupt toward side B, active low |

## Verification
The bench builds the block with its default parameters: four mailboxes per side, 16-bit words and a 6-bit offset. With these values every mapped offset from 0 to 10 can be reached, and so can unmapped offsets up to 63. Two byte lanes make lower-only and upper-only writes distinct, which is what separates raising writes from plain ones. Four sources per side allow several simultaneous causes, partial masking and a same-edge collision between a raise and a clear.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef enum logic [2:0] {
      RG_OWN,
      RG_PEER,
      RG_MASK,
      RG_CAUSE,
      RG_STAT,
      RG_NONE
   } mbx_region_e;

   // number of offsets the register window occupies
   function automatic int unsigned mbx_span(input int unsigned nbox);
      return 2 * nbox + 3;
   endfunction

   // map a window offset onto the register it selects
   function automatic mbx_region_e mbx_classify(input int unsigned off,
                                                input int unsigned nbox);
      if (off < nbox)               return RG_OWN;
      else if (off < 2 * nbox)      return RG_PEER;
      else if (off == 2 * nbox)     return RG_MASK;
      else if (off == 2 * nbox + 1) return RG_CAUSE;
      else if (off == 2 * nbox + 2) return RG_STAT;
      else                          return RG_NONE;
   endfunction

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
   import mbx_pkg::*;
#(
   parameter int NUM_BOX = 4,
   parameter int ADDR_W  = 6,
   localparam int IDX_W  = $clog2(NUM_BOX)
) (
   input  logic               box_n,
   input  logic               mem_en,
   input  logic               wr,
   input  logic               up_be,
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_BOX-1:0] own_we,
   output logic [NUM_BOX-1:0] up_wr,
   output logic [NUM_BOX-1:0] clr,
   output logic               mask_we,
   output logic               rd_en,
   output mbx_region_e        rd_rg,
   output logic [IDX_W-1:0]   rd_idx
);

   logic        acc;
   mbx_region_e rg;

   assign acc     = !box_n && !mem_en;
   assign rg      = mbx_classify(32'(addr), NUM_BOX);
   assign mask_we = acc && wr && (rg == RG_MASK);
   assign rd_en   = acc && !wr;
   assign rd_rg   = rg;
   // NUM_BOX is a power of two, so the low bits index both mailbox ranges
   assign rd_idx  = addr[IDX_W-1:0];

   for (genvar i = 0; i < NUM_BOX; i++) begin : g_box
      logic hit;
      assign hit       = (rd_idx == IDX_W'(i));
      assign own_we[i] = acc && wr && (rg == RG_OWN) && hit;
      assign up_wr[i]  = own_we[i] && up_be;
      assign clr[i]    = acc && !wr && up_be && (rg == RG_PEER) && hit;
   end

endmodule

// File: rtl/mbx_bank.sv
module mbx_bank #(
   parameter int  NUM_BOX = 4,
   parameter int  DATA_W  = 16,
   localparam int BYTES   = DATA_W / 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_BOX-1:0]        we,
   input  logic [BYTES-1:0]          be,
   input  logic [DATA_W-1:0]         wdata,
   output logic [NUM_BOX*DATA_W-1:0] boxes
);

   for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
      for (genvar k = 0; k < BYTES; k++) begin : g_lane
         logic [7:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lane_q <= '0;
            else if (we[b] && be[k])
               lane_q <= wdata[k*8 +: 8];
         end
         assign boxes[b*DATA_W + k*8 +: 8] = lane_q;
      end
   end

endmodule

// File: rtl/mbx_irq_unit.sv
module mbx_irq_unit #(
   parameter int                 NUM_BOX  = 4,
   parameter logic [NUM_BOX-1:0] MASK_RST = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_BOX-1:0] set,
   input  logic [NUM_BOX-1:0] clr,
   input  logic               mask_we,
   input  logic [NUM_BOX-1:0] mask_din,
   output logic [NUM_BOX-1:0] mask,
   output logic [NUM_BOX-1:0] pend,
   output logic [NUM_BOX-1:0] cause,
   output logic               irq_n
);

   logic [NUM_BOX-1:0] mask_q, pend_q, cause_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= MASK_RST;
         pend_q  <= '0;
         cause_q <= '0;
      end else begin
         if (mask_we)
            mask_q <= mask_din;
         // a raise on the same edge as a clear keeps the source pending
         pend_q  <= (pend_q & ~clr) | set;
         cause_q <= (cause_q & ~clr) | (set & ~mask_q);
      end
   end

   assign mask  = mask_q;
   assign pend  = pend_q;
   assign cause = cause_q;
   assign irq_n = ~(|cause_q);

endmodule

// File: rtl/mbx_rd_path.sv
module mbx_rd_path
   import mbx_pkg::*;
#(
   parameter int  NUM_BOX    = 4,
   parameter int  DATA_W     = 16,
   parameter bit  HOLD_RDATA = 1'b1,
   localparam int IDX_W      = $clog2(NUM_BOX)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rd_en,
   input  mbx_region_e               rd_rg,
   input  logic [IDX_W-1:0]          rd_idx,
   input  logic [NUM_BOX*DATA_W-1:0] own_flat,
   input  logic [NUM_BOX*DATA_W-1:0] peer_flat,
   input  logic [NUM_BOX-1:0]        mask,
   input  logic [NUM_BOX-1:0]        cause,
   input  logic [NUM_BOX-1:0]        stat,
   output logic [DATA_W-1:0]         rdata
);

   logic [DATA_W-1:0] sel;
   logic [DATA_W-1:0] rdata_q;

   always_comb begin
      case (rd_rg)
         RG_OWN:   sel = own_flat[rd_idx*DATA_W +: DATA_W];
         RG_PEER:  sel = peer_flat[rd_idx*DATA_W +: DATA_W];
         RG_MASK:  sel = DATA_W'(mask);
         RG_CAUSE: sel = DATA_W'(cause);
         RG_STAT:  sel = DATA_W'(stat);
         default:  sel = '0;
      endcase
   end

   if (HOLD_RDATA) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata_q <= '0;
         else if (rd_en)
            rdata_q <= sel;
      end
   end else begin : g_zero
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata_q <= '0;
         else
            rdata_q <= rd_en ? sel : '0;
      end
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
   import mbx_pkg::*;
#(
   parameter int                 NUM_BOX    = 4,
   parameter int                 DATA_W     = 16,
   parameter int                 ADDR_W     = 6,
   parameter bit                 HOLD_RDATA = 1'b1,
   parameter logic [NUM_BOX-1:0] MASK_RST   = '0,
   localparam int                BYTES      = DATA_W / 8,
   localparam int                IDX_W      = $clog2(NUM_BOX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_box_n,
   input  logic              a_mem_en,
   input  logic              a_wr,
   input  logic [BYTES-1:0]  a_be,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   output logic              a_irq_n,
   input  logic              b_box_n,
   input  logic              b_mem_en,
   input  logic              b_wr,
   input  logic [BYTES-1:0]  b_be,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              b_irq_n
);

   // elaboration-time parameter checks
   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if (NUM_BOX < 2 || (NUM_BOX & (NUM_BOX - 1)) != 0) begin : g_bad_count
      $error("NUM_BOX must be a power of two, at least 2");
   end
   if (NUM_BOX >= DATA_W) begin : g_bad_mask
      $error("NUM_BOX must be smaller than DATA_W");
   end
   if (mbx_span(NUM_BOX) > (1 << ADDR_W)) begin : g_bad_span
      $error("ADDR_W too small for the register window");
   end

   logic [NUM_BOX-1:0]        own_we_a, own_we_b;
   logic [NUM_BOX-1:0]        up_wr_a, up_wr_b;
   logic [NUM_BOX-1:0]        clr_a, clr_b;
   logic                      mask_we_a, mask_we_b;
   logic                      rd_en_a, rd_en_b;
   mbx_region_e               rd_rg_a, rd_rg_b;
   logic [IDX_W-1:0]          rd_idx_a, rd_idx_b;
   logic [NUM_BOX*DATA_W-1:0] box_a_flat, box_b_flat;
   logic [NUM_BOX-1:0]        mask_a, mask_b;
   logic [NUM_BOX-1:0]        stat_a, stat_b;
   logic [NUM_BOX-1:0]        cause_a, cause_b;

   mbx_port_dec #(.NUM_BOX(NUM_BOX), .ADDR_W(ADDR_W)) u_dec_a (
      .box_n(a_box_n), .mem_en(a_mem_en), .wr(a_wr), .up_be(a_be[BYTES-1]),
      .addr(a_addr), .own_we(own_we_a), .up_wr(up_wr_a), .clr(clr_a),
      .mask_we(mask_we_a), .rd_en(rd_en_a), .rd_rg(rd_rg_a), .rd_idx(rd_idx_a)
   );

   mbx_port_dec #(.NUM_BOX(NUM_BOX), .ADDR_W(ADDR_W)) u_dec_b (
      .box_n(b_box_n), .mem_en(b_mem_en), .wr(b_wr), .up_be(b_be[BYTES-1]),
      .addr(b_addr), .own_we(own_we_b), .up_wr(up_wr_b), .clr(clr_b),
      .mask_we(mask_we_b), .rd_en(rd_en_b), .rd_rg(rd_rg_b), .rd_idx(rd_idx_b)
   );

   mbx_bank #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W)) u_bank_a (
      .clk(clk), .rst_n(rst_n), .we(own_we_a), .be(a_be),
      .wdata(a_wdata), .boxes(box_a_flat)
   );

   mbx_bank #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W)) u_bank_b (
      .clk(clk), .rst_n(rst_n), .we(own_we_b), .be(b_be),
      .wdata(b_wdata), .boxes(box_b_flat)
   );

   // sources toward A are raised by B's upper-byte writes, and the reverse
   mbx_irq_unit #(.NUM_BOX(NUM_BOX), .MASK_RST(MASK_RST)) u_irq_a (
      .clk(clk), .rst_n(rst_n), .set(up_wr_b), .clr(clr_a),
      .mask_we(mask_we_a), .mask_din(a_wdata[NUM_BOX-1:0]),
      .mask(mask_a), .pend(stat_a), .cause(cause_a), .irq_n(a_irq_n)
   );

   mbx_irq_unit #(.NUM_BOX(NUM_BOX), .MASK_RST(MASK_RST)) u_irq_b (
      .clk(clk), .rst_n(rst_n), .set(up_wr_a), .clr(clr_b),
      .mask_we(mask_we_b), .mask_din(b_wdata[NUM_BOX-1:0]),
      .mask(mask_b), .pend(stat_b), .cause(cause_b), .irq_n(b_irq_n)
   );

   mbx_rd_path #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W), .HOLD_RDATA(HOLD_RDATA)) u_rd_a (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en_a), .rd_rg(rd_rg_a), .rd_idx(rd_idx_a),
      .own_flat(box_a_flat), .peer_flat(box_b_flat),
      .mask(mask_a), .cause(cause_a), .stat(stat_a), .rdata(a_rdata)
   );

   mbx_rd_path #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W), .HOLD_RDATA(HOLD_RDATA)) u_rd_b (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en_b), .rd_rg(rd_rg_b), .rd_idx(rd_idx_b),
      .own_flat(box_b_flat), .peer_flat(box_a_flat),
      .mask(mask_b), .cause(cause_b), .stat(stat_b), .rdata(b_rdata)
   );

endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
module mbx_irq_ctrl_chk #(
   parameter int NUM_BOX = 4,
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 6
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      a_box_n,
   input logic                      a_mem_en,
   input logic                      a_wr,
   input logic                      a_up,
   input logic [ADDR_W-1:0]         a_addr,
   input logic                      a_irq_n,
   input logic                      b_box_n,
   input logic                      b_mem_en,
   input logic                      b_wr,
   input logic                      b_up,
   input logic [ADDR_W-1:0]         b_addr,
   input logic                      b_irq_n,
   input logic [NUM_BOX*DATA_W-1:0] box_a_flat,
   input logic [NUM_BOX*DATA_W-1:0] box_b_flat,
   input logic [NUM_BOX-1:0]        mask_a,
   input logic [NUM_BOX-1:0]        mask_b,
   input logic [NUM_BOX-1:0]        stat_a,
   input logic [NUM_BOX-1:0]        stat_b,
   input logic [NUM_BOX-1:0]        cause_a,
   input logic [NUM_BOX-1:0]        cause_b
);

   logic               a_acc, b_acc;
   logic [NUM_BOX-1:0] a_upw, b_upw, a_clr, b_clr;

   assign a_acc = !a_box_n && !a_mem_en;
   assign b_acc = !b_box_n && !b_mem_en;

   for (genvar i = 0; i < NUM_BOX; i++) begin : g_src
      assign a_upw[i] = a_acc && a_wr && a_up && (a_addr == ADDR_W'(i));
      assign b_upw[i] = b_acc && b_wr && b_up && (b_addr == ADDR_W'(i));
      assign a_clr[i] = a_acc && !a_wr && a_up && (a_addr == ADDR_W'(NUM_BOX + i));
      assign b_clr[i] = b_acc && !b_wr && b_up && (b_addr == ADDR_W'(NUM_BOX + i));

      assert_raise_a_R11: assert property (@(posedge clk) disable iff (!rst_n)
         b_upw[i] |=> stat_a[i]);
      assert_raise_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
         a_upw[i] |=> stat_b[i]);
      assert_clear_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (a_clr[i] && !b_upw[i]) |=> !stat_a[i]);
      assert_clear_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (b_clr[i] && !a_upw[i]) |=> !stat_b[i]);
      assert_masked_no_cause_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(cause_a[i]) |-> $past(!mask_a[i]));
      assert_masked_no_cause_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(cause_b[i]) |-> $past(!mask_b[i]));
   end

   assert_cause_in_status_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_a & ~stat_a) == '0);
   assert_cause_in_status_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_b & ~stat_b) == '0);

   assert_irq_fall_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(a_irq_n) |-> $past(|b_upw));
   assert_irq_fall_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(b_irq_n) |-> $past(|a_upw));
   assert_irq_rise_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(a_irq_n) |-> $past(|a_clr));
   assert_irq_rise_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(b_irq_n) |-> $past(|b_clr));

   assert_box_hold_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(a_acc && a_wr) |-> $stable(box_a_flat));
   assert_box_hold_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(b_acc && b_wr) |-> $stable(box_b_flat));

endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk #(
   .NUM_BOX(NUM_BOX), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .a_box_n(a_box_n), .a_mem_en(a_mem_en), .a_wr(a_wr), .a_up(a_be[DATA_W/8-1]),
   .a_addr(a_addr), .a_irq_n(a_irq_n),
   .b_box_n(b_box_n), .b_mem_en(b_mem_en), .b_wr(b_wr), .b_up(b_be[DATA_W/8-1]),
   .b_addr(b_addr), .b_irq_n(b_irq_n),
   .box_a_flat(box_a_flat), .box_b_flat(box_b_flat),
   .mask_a(mask_a), .mask_b(mask_b), .stat_a(stat_a), .stat_b(stat_b),
   .cause_a(cause_a), .cause_b(cause_b)
);

// File: tb/sim_mbx_irq_ctrl.sv
module sim_mbx_irq_ctrl;

   localparam int AW = 6;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          a_box_n, a_mem_en, a_wr, b_box_n, b_mem_en, b_wr;
   logic [1:0]    a_be, b_be;
   logic [AW-1:0] a_addr, b_addr;
   logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
   logic          a_irq_n, b_irq_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   mbx_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n),
      .a_box_n(a_box_n), .a_mem_en(a_mem_en), .a_wr(a_wr), .a_be(a_be),
      .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq_n(a_irq_n),
      .b_box_n(b_box_n), .b_mem_en(b_mem_en), .b_wr(b_wr), .b_be(b_be),
      .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq_n(b_irq_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      a_box_n = 1'b1; a_mem_en = 1'b0; a_wr = 1'b0; a_be = '0; a_addr = '0; a_wdata = '0;
      b_box_n = 1'b1; b_mem_en = 1'b0; b_wr = 1'b0; b_be = '0; b_addr = '0; b_wdata = '0;
   endtask

   task automatic drive(input bit p, input bit wr, input logic [1:0] be,
                        input logic [AW-1:0] ad, input logic [DW-1:0] d,
                        input bit sel_n = 1'b0, input bit men = 1'b0);
      if (!p) begin
         a_box_n = sel_n; a_mem_en = men; a_wr = wr; a_be = be; a_addr = ad; a_wdata = d;
      end else begin
         b_box_n = sel_n; b_mem_en = men; b_wr = wr; b_be = be; b_addr = ad; b_wdata = d;
      end
   endtask

   // inputs change at the falling edge; results are sampled one falling edge later
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic wrt(input bit p, input logic [1:0] be, input logic [AW-1:0] ad,
                      input logic [DW-1:0] d);
      drive(p, 1'b1, be, ad, d);
      step();
   endtask

   task automatic rd(input bit p, input logic [1:0] be, input logic [AW-1:0] ad,
                     output logic [DW-1:0] v);
      drive(p, 1'b0, be, ad, '0);
      step();
      v = p ? b_rdata : a_rdata;
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      chk("R12 a_irq_n after reset", a_irq_n, 1);
      chk("R12 b_irq_n after reset", b_irq_n, 1);
      chk("R12 a_rdata after reset", a_rdata, 0);
      rd(0, 2'b11, 10, v); chk("R12 status A after reset", v, 0);
      rd(1, 2'b11, 8, v);  chk("R12 mask B after reset", v, 0);
      rd(0, 2'b11, 9, v);  chk("R12 cause A after reset", v, 0);
      rd(1, 2'b11, 3, v);  chk("R12 mailbox B3 after reset", v, 0);
   endtask

   task automatic t_own_rw();
      logic [DW-1:0] v;
      wrt(0, 2'b11, 2, 16'h1234);
      chk("R5 upper write raises toward B", b_irq_n, 0);
      chk("R10 irq A unaffected", a_irq_n, 1);
      rd(0, 2'b11, 2, v);  chk("R3 owner readback", v, 16'h1234);
      rd(1, 2'b01, 6, v);  chk("R2 peer view of A2", v, 16'h1234);
      chk("R6 lower-only read keeps source", b_irq_n, 0);
      rd(1, 2'b11, 10, v); chk("R9 status B", v, 16'h0004);
      rd(1, 2'b11, 9, v);  chk("R8 cause B", v, 16'h0004);
      step();
      chk("R4 rdata holds while idle", b_rdata, 16'h0004);
      rd(1, 2'b11, 6, v);  chk("R4 peer read data", v, 16'h1234);
      chk("R6 upper read clears irq", b_irq_n, 1);
      rd(1, 2'b11, 6, v);  chk("R6 contents kept after clearing read", v, 16'h1234);
      rd(1, 2'b11, 10, v); chk("R9 status B cleared", v, 0);
   endtask

   task automatic t_byte_lanes();
      logic [DW-1:0] v;
      wrt(0, 2'b01, 1, 16'h00CD);
      chk("R5 lower-only write raises nothing", b_irq_n, 1);
      rd(0, 2'b11, 1, v);  chk("R3 lower lane written", v, 16'h00CD);
      wrt(0, 2'b10, 1, 16'hEF99);
      chk("R5 upper-only write raises", b_irq_n, 0);
      rd(0, 2'b11, 1, v);  chk("R3 only upper lane replaced", v, 16'hEFCD);
      rd(1, 2'b10, 5, v);  chk("R6 clearing read data", v, 16'hEFCD);
      chk("R6 irq B released", b_irq_n, 1);
   endtask

   task automatic t_peer_write_ignored();
      logic [DW-1:0] v;
      wrt(1, 2'b11, 4, 16'hFFFF);
      rd(0, 2'b11, 0, v);  chk("R3 peer write to A0 ignored", v, 0);
      chk("R5 peer-offset write raises nothing toward A", a_irq_n, 1);
      chk("R5 peer-offset write raises nothing toward B", b_irq_n, 1);
      wrt(1, 2'b11, 9, 16'h000F);
      rd(1, 2'b11, 9, v);  chk("R3 cause write ignored", v, 0);
      wrt(1, 2'b11, 10, 16'h000F);
      rd(1, 2'b11, 10, v); chk("R3 status write ignored", v, 0);
   endtask

   task automatic t_mask();
      logic [DW-1:0] v;
      wrt(1, 2'b11, 8, 16'h0008);
      rd(1, 2'b11, 8, v);  chk("R7 mask readback", v, 16'h0008);
      wrt(0, 2'b11, 3, 16'hA55A);
      chk("R7 masked source keeps irq high", b_irq_n, 1);
      rd(1, 2'b11, 10, v); chk("R9 masked source in status", v, 16'h0008);
      rd(1, 2'b11, 9, v);  chk("R8 masked source not in cause", v, 0);
      wrt(1, 2'b11, 8, 16'h0000);
      chk("R8 unmask does not raise irq", b_irq_n, 1);
      rd(1, 2'b11, 9, v);  chk("R8 cause stays empty after unmask", v, 0);
      rd(1, 2'b10, 7, v);  chk("R6 read of masked mailbox", v, 16'hA55A);
      rd(1, 2'b11, 10, v); chk("R9 masked source cleared", v, 0);
   endtask

   task automatic t_cause_multi();
      logic [DW-1:0] v;
      wrt(1, 2'b11, 0, 16'h1100);
      wrt(1, 2'b11, 2, 16'h2200);
      chk("R10 irq A low", a_irq_n, 0);
      rd(0, 2'b11, 9, v);  chk("R8 two causes", v, 16'h0005);
      rd(0, 2'b10, 4, v);  chk("R2 A reads B0", v, 16'h1100);
      chk("R10 irq A low while one cause left", a_irq_n, 0);
      rd(0, 2'b11, 9, v);  chk("R8 remaining cause", v, 16'h0004);
      rd(0, 2'b10, 6, v);
      chk("R10 irq A high when cause empty", a_irq_n, 1);
   endtask

   task automatic t_collision();
      logic [DW-1:0] v;
      wrt(1, 2'b11, 1, 16'h3300);
      chk("R5 B1 raises toward A", a_irq_n, 0);
      drive(1, 1'b1, 2'b10, 1, 16'h4400);
      drive(0, 1'b0, 2'b10, 5, '0);
      step();
      chk("R4 read returns pre-write value", a_rdata, 16'h3300);
      chk("R11 write beats clear on irq", a_irq_n, 0);
      rd(0, 2'b11, 10, v); chk("R11 source still pending", v, 16'h0002);
      rd(0, 2'b10, 5, v);  chk("R6 later clear read data", v, 16'h4400);
      chk("R6 irq A released", a_irq_n, 1);
   endtask

   task automatic t_qualify();
      logic [DW-1:0] v;
      wrt(0, 2'b01, 0, 16'h0077);
      rd(0, 2'b11, 0, v);  chk("R3 A0 lower write", v, 16'h0077);
      drive(0, 1'b1, 2'b11, 0, 16'hBEEF, 1'b0, 1'b1);
      step();
      chk("R1 memory enable blocks raise", b_irq_n, 1);
      drive(0, 1'b1, 2'b11, 0, 16'hBEEF, 1'b1, 1'b0);
      step();
      chk("R1 deselect blocks raise", b_irq_n, 1);
      drive(0, 1'b0, 2'b11, 10, '0, 1'b0, 1'b1);
      step();
      chk("R1 blocked read keeps rdata", a_rdata, 16'h0077);
      rd(0, 2'b11, 0, v);  chk("R1 blocked writes left A0", v, 16'h0077);
   endtask

   task automatic t_map_misc();
      logic [DW-1:0] v;
      rd(0, 2'b11, 11, v); chk("R2 offset 11 reads zero", v, 0);
      rd(0, 2'b11, 63, v); chk("R2 offset 63 reads zero", v, 0);
      wrt(0, 2'b11, 8, 16'hFFF5);
      rd(0, 2'b11, 8, v);  chk("R7 mask keeps low bits only", v, 16'h0005);
      wrt(0, 2'b11, 8, 16'h0000);
      rd(0, 2'b11, 8, v);  chk("R7 mask cleared", v, 0);
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_own_rw();
      t_byte_lanes();
      t_peer_write_ignored();
      t_mask();
      t_cause_multi();
      t_collision();
      t_qualify();
      t_map_misc();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule